// File: doc/BRIEF.md
# IDE Byte-to-Word Data Bridge

This block places a 16-bit IDE task file behind an 8-bit CPU I/O bus. It decodes ports from the low eight address lines alone. The seven non-data task-file registers pass through as single byte transfers.

The data register is handled in two steps, tracked by an odd/even phase flag. On an odd read, the bridge fetches a full 16-bit word from the drive and returns its low byte. On the even read that follows, it returns the held high byte and does not touch the drive. On an odd write, the bridge only stores the low byte. On the even write, it sends the stored byte and the current byte to the drive together as one word.

The phase flag returns to odd on any access to a non-data task-file register or to the device's control port. Traffic on other ports leaves the phase as it is.

All interface signals are sampled on one clock. A CPU access is one clock cycle with `io_rd` or `io_wr` high, and the IDE strobes are driven in that same cycle.

Top module: `ide_byte_bridge`

## Requirements
- R1: A CPU access whose address matches `101nnn11` (bits 7..5 = 101, bits 1..0 = 11) selects task-file register `nnn`. That value is driven on `ide_reg` while `ide_cs` is high. Any other address never raises `ide_cs`, `ide_rd`, `ide_wr` or `io_rd_hit`.
- R2: After reset, the IDE strobes are low and the phase is odd, so the first data-register access is treated as odd.
- R3: An odd read of register 0 raises `ide_rd` and `ide_cs` for that cycle. It returns `ide_rdata[7:0]` on `io_rdata`, keeps `ide_rdata[15:8]`, and moves the phase to even.
- R4: An even read of register 0 leaves `ide_rd`, `ide_wr` and `ide_cs` low. It returns the held byte on `io_rdata` and moves the phase to odd.
- R5: An odd write to register 0 raises no IDE strobe. It keeps `io_wdata` as the held byte and moves the phase to even.
- R6: An even write to register 0 raises `ide_wr` and `ide_cs` once. It drives `ide_wdata` = {`io_wdata`, held byte}, with the current byte in bits 15..8, and moves the phase to odd.
- R7: A read or write of registers 1..7 raises the matching IDE strobe. Reads return `ide_rdata[7:0]`, writes drive `ide_wdata` = {8'h00, `io_wdata`}, and the phase becomes odd.
- R8: A read or write of the control port (0xE3) raises no IDE strobe and no `io_rd_hit`, and it makes the phase odd.
- R9: An access to any port outside the task file and the control port changes neither the phase nor the held byte.
- R10: Cycles with neither `io_rd` nor `io_wr` high change nothing and drive all strobes low. `io_rdata` is zero whenever `io_rd_hit` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 8 | Low CPU address byte |
| io_rd | input | 1 | CPU read access this cycle |
| io_wr | input | 1 | CPU write access this cycle |
| io_wdata | input | 8 | CPU write byte |
| io_rdata | output | 8 | Byte returned to the CPU |
| io_rd_hit | output | 1 | Bridge drives `io_rdata` this cycle |
| ide_rdata | input | 16 | Word read from the drive |
| ide_wdata | output | 16 | Word written to the drive |
| ide_reg | output | 3 | Task-file register select |
| ide_cs | output | 1 | Task-file chip select |
| ide_rd | output | 1 | Drive read strobe |
| ide_wr | output | 1 | Drive write strobe |

## Verification
The bench uses the default byte width of 8 and control port 0xE3, so the 16-bit drive word maps directly onto two CPU bytes. With these values, a random walk over data, task-file, control and foreign ports reaches every phase transition. It also covers reads and writes that share the held byte, and ports that differ from a device port in a single address bit.

// File: rtl/ide_byte_bridge.sv
module ide_byte_bridge #(
  parameter int          BW        = 8,
  parameter logic [7:0]  CTRL_PORT = 8'hE3,
  parameter logic [2:0]  CMD_TAG   = 3'b101
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         io_addr,
  input  logic               io_rd,
  input  logic               io_wr,
  input  logic [BW-1:0]      io_wdata,
  output logic [BW-1:0]      io_rdata,
  output logic               io_rd_hit,
  input  logic [2*BW-1:0]    ide_rdata,
  output logic [2*BW-1:0]    ide_wdata,
  output logic [2:0]         ide_reg,
  output logic               ide_cs,
  output logic               ide_rd,
  output logic               ide_wr
);
  localparam int DW = 2 * BW;

  logic          odd_q;
  logic [BW-1:0] hold_q;

  logic       access, wr_only, cmd_hit, ctrl_hit, data_hit, task_hit;
  logic [2:0] sel;

  assign access   = io_rd | io_wr;
  assign wr_only  = io_wr & ~io_rd;
  assign sel      = io_addr[4:2];
  assign cmd_hit  = access && io_addr[7:5] == CMD_TAG && io_addr[1:0] == 2'b11;
  assign ctrl_hit = access && io_addr == CTRL_PORT && !cmd_hit;
  assign data_hit = cmd_hit && sel == 3'd0;
  assign task_hit = cmd_hit && sel != 3'd0;

  assign ide_rd    = cmd_hit & io_rd   & (task_hit | odd_q);
  assign ide_wr    = cmd_hit & wr_only & (task_hit | ~odd_q);
  assign ide_cs    = ide_rd | ide_wr;
  assign ide_reg   = cmd_hit ? sel : 3'd0;
  assign ide_wdata = !ide_wr  ? '0 :
                     data_hit ? {io_wdata, hold_q} : {{BW{1'b0}}, io_wdata};
  assign io_rd_hit = cmd_hit & io_rd;
  assign io_rdata  = !io_rd_hit           ? '0 :
                     (data_hit && !odd_q) ? hold_q : ide_rdata[BW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      odd_q  <= 1'b1;
      hold_q <= '0;
    end else if (data_hit) begin
      odd_q <= ~odd_q;
      if (odd_q)
        hold_q <= io_rd ? ide_rdata[DW-1:BW] : io_wdata;
    end else if (task_hit || ctrl_hit) begin
      odd_q <= 1'b1;
    end
  end

  // R10
  rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ide_rd && ide_wr));
  // R1
  foreign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (access && !(io_addr[7:5] == CMD_TAG && io_addr[1:0] == 2'b11)) |-> !ide_cs && !io_rd_hit);
  // R9
  foreign_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_hit && !ctrl_hit) |=> $stable(odd_q) && $stable(hold_q));
  // R3
  odd_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ide_rd && ide_reg == 3'd0) |=> !odd_q);
  // R6
  even_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ide_wr && ide_reg == 3'd0) |=> odd_q);
  // R5
  odd_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_hit && wr_only && odd_q) |-> !ide_cs);
  // R8
  ctrl_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_hit |=> odd_q);
endmodule

// File: tb/tb_ide_byte_bridge.sv
module tb_ide_byte_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  io_addr = '0;
  logic        io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        io_rd_hit;
  logic [15:0] ide_rdata = '0;
  logic [15:0] ide_wdata;
  logic [2:0]  ide_reg;
  logic        ide_cs, ide_rd, ide_wr;

  int checks = 0, errors = 0;
  bit done = 0;
  bit m_odd;
  byte unsigned m_hold;

  always #2 clk = ~clk;

  ide_byte_bridge dut (.*);

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic access(bit rd, bit wr, byte unsigned a, byte unsigned wd, logic [15:0] rdw);
    bit cmd, ctrl, e_rd, e_wr, e_hit;
    int r;
    logic [15:0] e_wd;
    byte unsigned e_rdata;
    string tag;
    @(negedge clk);
    io_rd = rd; io_wr = wr; io_addr = a; io_wdata = wd; ide_rdata = rdw;
    #1;
    cmd  = (rd || wr) && a[7:5] == 3'b101 && a[1:0] == 2'b11;
    ctrl = (rd || wr) && a == 8'hE3;
    r = a[4:2];
    e_rd = 0; e_wr = 0; e_wd = 0; e_rdata = 0; e_hit = cmd && rd;
    if (!(rd || wr)) tag = "R10";
    else if (cmd && r == 0) begin
      if (rd) begin
        if (m_odd) begin tag = "R3"; e_rd = 1; e_rdata = rdw[7:0]; m_hold = rdw[15:8]; end
        else begin tag = "R4"; e_rdata = m_hold; end
      end else begin
        if (m_odd) begin tag = "R5"; m_hold = wd; end
        else begin tag = "R6"; e_wr = 1; e_wd = {wd, m_hold}; end
      end
      m_odd = !m_odd;
    end else if (cmd) begin
      tag = "R7"; e_rd = rd; e_wr = !rd; m_odd = 1;
      if (rd) e_rdata = rdw[7:0]; else e_wd = {8'h00, wd};
    end else if (ctrl) begin tag = "R8"; m_odd = 1; end
    else tag = "R9";
    chk(tag, "ide_rd", ide_rd, e_rd);
    chk(tag, "ide_wr", ide_wr, e_wr);
    chk(tag, "ide_cs", ide_cs, e_rd | e_wr);
    chk(tag, "io_rd_hit", io_rd_hit, e_hit);
    chk(tag, "io_rdata", io_rdata, e_rdata);
    if (e_wr) chk(tag, "ide_wdata", ide_wdata, e_wd);
    if (e_rd | e_wr) chk("R1", "ide_reg", ide_reg, r);
  endtask

  initial begin
    byte unsigned ports [12] = '{8'hA3, 8'hA7, 8'hAB, 8'hBF, 8'hE3, 8'hA2,
                                 8'h23, 8'hE7, 8'hA1, 8'hC3, 8'hA3, 8'hA3};
    m_odd = 1; m_hold = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R2 reset state
    chk("R2", "ide_cs", ide_cs, 0);
    chk("R2", "io_rd_hit", io_rd_hit, 0);
    access(1, 0, 8'hA3, 0, 16'hBEEF);   // R2 first read is odd, R3
    access(1, 0, 8'hA3, 0, 16'h1111);   // R4
    access(0, 0, 8'h00, 0, 16'h0);      // R10
    access(0, 1, 8'hA3, 8'h34, 16'h0);  // R5
    access(0, 1, 8'h23, 8'h99, 16'h0);  // R9 foreign write
    access(0, 0, 8'h00, 0, 16'h0);
    access(0, 1, 8'hA3, 8'h12, 16'h0);  // R6 -> 0x1234
    access(1, 0, 8'hA3, 0, 16'h5678);   // R3
    access(0, 1, 8'hAF, 8'h07, 16'hAAAA); // R7 write resets phase
    access(1, 0, 8'hA3, 0, 16'h9ABC);   // R3 again odd
    access(1, 0, 8'hE3, 0, 16'h0);      // R8
    access(1, 0, 8'hA3, 0, 16'h4321);   // odd after ctrl
    access(1, 0, 8'hBF, 0, 16'h5A50);   // R7 read
    access(0, 1, 8'hA3, 8'h77, 16'h0);  // R5
    access(1, 0, 8'hA2, 0, 16'h0);      // R9
    access(1, 0, 8'hA3, 0, 16'h0);      // R4 returns 0x77
    for (int i = 0; i < 400; i++)
      access($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
             ports[$urandom_range(0, 11)], 8'($urandom), 16'($urandom));
    access(0, 0, 8'h00, 0, 16'h0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule